// File: doc/BRIEF.md
# Two-Channel Synchronized PWM Timer

This block holds two 16-bit up-counters that advance together on a shared tick input. Each channel has one period register and three duty registers. Each duty register drives its own output pin, so the block has six PWM outputs. A counter returns to zero on the tick where it equals its period register. On that same tick, every pin of the channel takes its period level. When a pin's duty register matches the counter, the pin takes its duty level instead. A polarity bit for each pin selects which of the two levels is high.

A synchronous mode ties the channels together. In this mode, a write to either counter loads both counters at once. If channel 1 also has synchronous clearing selected, it restarts on channel 0's wrap and ignores its own period, which gives two-phase waveforms that share one cycle. While a channel is stopped, its pins hold an idle level taken from a configuration register. Software programs everything through a single write port.

Top module: `pwm_sync_timer`

## Requirements
- R1: While a channel's start bit is set, its counter adds one on each tick. On a tick where the counter equals its period register P, the counter returns to 0, so one cycle lasts P+1 ticks. The period registers sit at address 0x3 for channel 0 and 0xB for channel 1.
- R2: Duty register k of channel c drives pin 3*c+k. Channel 0 has duty registers at addresses 0x4, 0x5 and 0x6, and channel 1 has them at 0xC, 0xD and 0xE.
- R3: When a pin's polarity bit is 0, the pin goes high on the channel wrap and low on its duty match. With duty D < P, the pin is high for D+1 ticks of each cycle.
- R4: When a pin's polarity bit is 1, the pin goes low on the channel wrap and high on its duty match. With duty D < P, the pin is high for P-D ticks of each cycle.
- R5: While a channel is stopped, each of its pins drives its idle bit XOR its polarity bit. The configuration register at address 0x1 holds the idle bits of pins 0 to 5 in bits 5:0 and their polarity bits in bits 13:8. After reset all pins are 0.
- R6: A write to the configuration register changes the idle and polarity bits only for pins whose channel is stopped. The bits of pins on a running channel keep their old values.
- R7: If a duty match and the wrap happen on the same tick, the pin takes the wrap level. With D = P and polarity 0, the pin therefore stays high.
- R8: When sync mode (bit 2 of the control register at address 0x0) and channel 1 sync clearing (bit 3) are both set, channel 1 clears on the tick on which channel 0 wraps, and its own period register is not used.
- R9: In sync mode, a write to either counter register (0x2 or 0xA) loads both counters with the written value in the same cycle. With sync mode clear, the write loads only the addressed counter.
- R10: Control bits 0 and 1 start channels 0 and 1. A counter changes only on a tick while it is started, or on a write. When ticks arrive on every other clock, every duration doubles in clock cycles.
- R11: An output changes on the clock edge that ends the cycle in which the tick matched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 16 | Write data |
| tick | input | 1 | Shared count-enable pulse |
| pwm_out | output | 6 | PWM outputs, pin 3*c+k belongs to channel c, duty k |

## Verification
The main function is tried with four groups of patterns:
- Three duty values under one period with polarity 0 show whether each pin follows its own duty register.
- Three duty values with polarity 1, including duty 0 and duty P-1, show that the high time inverts correctly at both ends of the range.
- A duty equal to the period checks the priority rule.
- A half-rate tick separates counting on ticks from counting on clocks.

Sync clearing is tried with channel 1's own period set far above channel 0's, so only the shared wrap can produce the expected cycle. Sync preset loads both counters, which previously held different values, and then compares the two channels' pin waveforms cycle by cycle.

// File: rtl/pwm_tmr_pkg.sv
// Shared constants and types for the two-channel PWM timer.
// Assumes exactly two channels, since sync clearing links channel 1 to channel 0.
package pwm_tmr_pkg;
    localparam int NUM_CH  = 2;
    localparam int ADDR_W  = 4;
    localparam int POL_LSB = 8;

    localparam logic [ADDR_W-1:0] A_CTRL   = 4'h0;
    localparam logic [ADDR_W-1:0] A_OUTCFG = 4'h1;

    // low three address bits select the register inside a channel; bit 3 selects the channel
    localparam logic [2:0] SUB_CNT   = 3'd2;
    localparam logic [2:0] SUB_PER   = 3'd3;
    localparam logic [2:0] SUB_DUTY0 = 3'd4;

    typedef struct packed {
        logic              sync_clr1;
        logic              sync_en;
        logic [NUM_CH-1:0] start;
    } ctrl_t;
endpackage

// File: rtl/pwm_tmr_regs.sv
// Register file: control, periods, duties, and the idle and polarity bits of each pin.
// Idle and polarity bits of a pin change only while that pin's channel is stopped.
// Also decodes counter writes into per-channel load strobes, honouring sync preset.
module pwm_tmr_regs
    import pwm_tmr_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DUTY_N = 3,
    parameter int PIN_N  = NUM_CH * DUTY_N
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            wr_addr,
    input  logic [CNT_W-1:0]             wr_data,
    output ctrl_t                        ctrl,
    output logic [NUM_CH-1:0][CNT_W-1:0] period,
    output logic [PIN_N-1:0][CNT_W-1:0]  duty,
    output logic [PIN_N-1:0]             idle_lvl,
    output logic [PIN_N-1:0]             pol,
    output logic [NUM_CH-1:0]            cnt_load
);
    localparam int CTRL_W = $bits(ctrl_t);

    // Control register write
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl <= '0;
        else if (wr_en && wr_addr == A_CTRL)
            ctrl <= ctrl_t'(wr_data[CTRL_W-1:0]);
    end

    logic cnt_wr_any;
    assign cnt_wr_any = wr_en && (wr_addr[2:0] == SUB_CNT);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam logic [ADDR_W-1:0] BASE = ADDR_W'(c * 8);

        // Counter load strobe: the addressed channel, or both channels in sync mode
        assign cnt_load[c] = cnt_wr_any && (ctrl.sync_en || wr_addr[3] == c[0]);

        // Period register write
        always_ff @(posedge clk) begin
            if (!rst_n)
                period[c] <= '1;
            else if (wr_en && wr_addr == (BASE | ADDR_W'(SUB_PER)))
                period[c] <= wr_data;
        end

        for (genvar k = 0; k < DUTY_N; k++) begin : g_pin
            localparam int P = c * DUTY_N + k;
            localparam logic [ADDR_W-1:0] DADDR = BASE | ADDR_W'(SUB_DUTY0 + 3'(k));

            // Duty register write
            always_ff @(posedge clk) begin
                if (!rst_n)
                    duty[P] <= '1;
                else if (wr_en && wr_addr == DADDR)
                    duty[P] <= wr_data;
            end

            // Idle and polarity bits; a running channel locks them
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    idle_lvl[P] <= 1'b0;
                    pol[P]      <= 1'b0;
                end else if (wr_en && wr_addr == A_OUTCFG && !ctrl.start[c]) begin
                    idle_lvl[P] <= wr_data[P];
                    pol[P]      <= wr_data[POL_LSB + P];
                end
            end

            // R6: a running channel's pin configuration holds through any write
            assert_cfg_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
                ctrl.start[c] |=> $stable(pol[P]) && $stable(idle_lvl[P]))
                else $error("pin config changed while channel running");
        end
    end
endmodule

// File: rtl/pwm_tmr_counter.sv
// One channel counter. On a write load it takes the written value. Otherwise it
// steps on a tick while running, and wraps to 0 on its own period match or, when
// use_ext_clr is set, on an external clear event. Load has priority over counting.
module pwm_tmr_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] period,
    input  logic             use_ext_clr,
    input  logic             ext_clr,
    output logic [CNT_W-1:0] cnt,
    output logic             step,
    output logic             wrap
);
    logic own_match;

    assign step      = run && tick && !load;
    assign own_match = (cnt == period);
    assign wrap      = step && (use_ext_clr ? ext_clr : own_match);

    // Counter update: load, wrap, step or hold
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (wrap)
            cnt <= '0;
        else if (step)
            cnt <= cnt + CNT_W'(1);
    end

    // R1: a tick at the period value returns the counter to zero
    assert_wrap_at_period_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && !load && !use_ext_clr && cnt == period) |=> cnt == '0)
        else $error("counter did not wrap at period");

    // R10: without a load, a stopped counter holds its value
    assert_hold_when_stopped_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load) |=> $stable(cnt))
        else $error("stopped counter moved");

    // R10: a running tick without wrap advances by exactly one
    assert_step_by_one_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && !load && !wrap) |=> cnt == $past(cnt) + CNT_W'(1))
        else $error("counter step wrong");
endmodule

// File: rtl/pwm_tmr_pin.sv
// One PWM output. While stopped, it drives idle XOR polarity. While running, a wrap
// sets the level to NOT polarity and a duty match sets it to polarity, with the wrap
// taking priority. The output is registered, so it changes one edge after the match.
module pwm_tmr_pin #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             step,
    input  logic             wrap,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] duty,
    input  logic             idle_lvl,
    input  logic             pol,
    output logic             pwm
);
    logic duty_hit;

    assign duty_hit = step && (cnt == duty);

    // Output level: idle, wrap level, or duty level
    always_ff @(posedge clk) begin
        if (!rst_n)
            pwm <= 1'b0;
        else if (!run)
            pwm <= idle_lvl ^ pol;
        else if (wrap)
            pwm <= ~pol;
        else if (duty_hit)
            pwm <= pol;
    end

    // R7: when both matches fall on one tick, the wrap level is taken
    assert_wrap_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && wrap && duty_hit) |=> pwm == !$past(pol))
        else $error("duty beat wrap");

    // R5: a stopped channel's pin follows idle XOR polarity
    assert_idle_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> pwm == $past(idle_lvl ^ pol))
        else $error("idle level wrong");

    // R3: a duty match alone drives the polarity level
    assert_duty_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && duty_hit && !wrap) |=> pwm == $past(pol))
        else $error("duty level wrong");
endmodule

// File: rtl/pwm_sync_timer.sv
// Top level: two counters that share one tick, with three PWM pins per channel.
// Channel 1 may take channel 0's wrap as its clear source (sync clearing), and
// counter writes in sync mode preset both channels together.
module pwm_sync_timer
    import pwm_tmr_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DUTY_N = 3,
    localparam int PIN_N = NUM_CH * DUTY_N
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [3:0]        wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic              tick,
    output logic [PIN_N-1:0]  pwm_out
);
    ctrl_t                        ctrl;
    logic [NUM_CH-1:0][CNT_W-1:0] period;
    logic [PIN_N-1:0][CNT_W-1:0]  duty;
    logic [PIN_N-1:0]             idle_lvl;
    logic [PIN_N-1:0]             pol;
    logic [NUM_CH-1:0]            cnt_load;
    logic [NUM_CH-1:0][CNT_W-1:0] cnt;
    logic [NUM_CH-1:0]            step;
    logic [NUM_CH-1:0]            wrap;
    logic [NUM_CH-1:0]            use_ext;
    logic [NUM_CH-1:0]            ext_clr;

    pwm_tmr_regs #(.CNT_W(CNT_W), .DUTY_N(DUTY_N), .PIN_N(PIN_N)) i_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .ctrl     (ctrl),
        .period   (period),
        .duty     (duty),
        .idle_lvl (idle_lvl),
        .pol      (pol),
        .cnt_load (cnt_load)
    );

    // Clear source selection: channel 0 always uses its own period
    assign use_ext[0] = 1'b0;
    assign ext_clr[0] = 1'b0;
    assign use_ext[1] = ctrl.sync_en && ctrl.sync_clr1;
    assign ext_clr[1] = wrap[0];

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        pwm_tmr_counter #(.CNT_W(CNT_W)) i_cnt (
            .clk         (clk),
            .rst_n       (rst_n),
            .run         (ctrl.start[c]),
            .tick        (tick),
            .load        (cnt_load[c]),
            .load_val    (wr_data),
            .period      (period[c]),
            .use_ext_clr (use_ext[c]),
            .ext_clr     (ext_clr[c]),
            .cnt         (cnt[c]),
            .step        (step[c]),
            .wrap        (wrap[c])
        );

        for (genvar k = 0; k < DUTY_N; k++) begin : g_pin
            localparam int P = c * DUTY_N + k;
            pwm_tmr_pin #(.CNT_W(CNT_W)) i_pin (
                .clk      (clk),
                .rst_n    (rst_n),
                .run      (ctrl.start[c]),
                .step     (step[c]),
                .wrap     (wrap[c]),
                .cnt      (cnt[c]),
                .duty     (duty[P]),
                .idle_lvl (idle_lvl[P]),
                .pol      (pol[P]),
                .pwm      (pwm_out[P])
            );
        end
    end

    // R8: under sync clearing, channel 1 restarts on the tick channel 0 wraps
    assert_sync_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (use_ext[1] && wrap[0] && step[1]) |=> cnt[1] == '0)
        else $error("channel 1 missed sync clear");

    // R9: a counter write in sync mode leaves both counters equal
    assert_sync_preset_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ctrl.sync_en && wr_addr[2:0] == SUB_CNT) |=> cnt[0] == cnt[1])
        else $error("sync preset left counters apart");

    // R9: without sync mode a counter write loads only one channel
    assert_single_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !ctrl.sync_en && wr_addr[2:0] == SUB_CNT) |-> $onehot0(cnt_load))
        else $error("non-sync write loaded both");
endmodule

// File: tb/test_pwm_sync_timer.sv
// Scoreboard bench. Driver steps push expected pulse shapes into a queue, and a
// monitor measures the named pin's high time and period and compares them.
module test_pwm_sync_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        tick = 1'b0;
    logic [5:0]  pwm;

    int checks = 0;
    int fails = 0;
    bit tick_half = 1'b0;
    bit finished = 1'b0;

    typedef struct {
        int    pin;
        int    high;
        int    per;
        string req;
    } exp_t;
    exp_t q[$];

    pwm_sync_timer i_pwm_sync_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .tick    (tick),
        .pwm_out (pwm)
    );

    always #10 clk = ~clk;

    // Tick source: every clock, or every other clock at half rate
    always @(negedge clk) tick <= tick_half ? ~tick : 1'b1;

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [15:0] d);
        @(negedge clk);
        wr_addr = a;
        wr_data = d;
        wr_en   = 1'b1;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_pulse(int pin, int high, int per, string req);
        exp_t e;
        e.pin = pin; e.high = high; e.per = per; e.req = req;
        q.push_back(e);
    endtask

    task automatic drain();
        wait (q.size() == 0);
    endtask

    // Monitor: measure one full pulse of the expected pin and compare
    initial begin
        forever begin
            exp_t e;
            int h;
            int p;
            wait (q.size() > 0);
            e = q[0];
            @(negedge clk);
            while (pwm[e.pin] !== 1'b0) @(negedge clk);
            while (pwm[e.pin] !== 1'b1) @(negedge clk);
            h = 0;
            while (pwm[e.pin] === 1'b1) begin h++; @(negedge clk); end
            p = h;
            while (pwm[e.pin] === 1'b0) begin p++; @(negedge clk); end
            check(h == e.high, e.req, $sformatf("pin%0d high time", e.pin), h, e.high);
            check(p == e.per,  e.req, $sformatf("pin%0d period", e.pin), p, e.per);
            void'(q.pop_front());
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual 150000 cycles expected completion earlier");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int lows;
        int mism;
        int rises;
        logic prev;
        idle(3);
        rst_n = 1'b1;
        idle(2);
        check(pwm == 6'b0, "R5", "pins after reset", pwm, 0);

        // R5: idle level = idle XOR polarity while stopped
        wr(4'h1, 16'h062D);
        idle(2);
        check(pwm == 6'b101011, "R5", "idle levels", pwm, 6'b101011);
        wr(4'h1, 16'h0000);
        idle(2);

        // R1 R2 R3: channel 0, polarity 0, period 9, duties 3/5/7
        wr(4'h3, 16'd9);
        wr(4'h4, 16'd3);
        wr(4'h5, 16'd5);
        wr(4'h6, 16'd7);
        wr(4'h2, 16'd0);
        wr(4'h0, 16'h0001);
        expect_pulse(0, 4, 10, "R3");
        expect_pulse(1, 6, 10, "R2");
        expect_pulse(2, 8, 10, "R1");
        drain();

        // R6: config writes reach only the stopped channel's pins
        wr(4'h1, 16'h003F);
        idle(2);
        check(pwm[5:3] == 3'b111, "R6", "stopped channel pins", pwm[5:3], 7);
        wr(4'h0, 16'h0000);
        idle(2);
        check(pwm[2:0] == 3'b000, "R6", "running channel kept old config", pwm[2:0], 0);
        wr(4'h1, 16'h0000);
        idle(2);

        // R4: channel 1, polarity 1, period 11, duties 2/0/10
        wr(4'h1, 16'h3800);
        idle(2);
        check(pwm == 6'b111000, "R5", "polarity-1 idle levels", pwm, 6'b111000);
        wr(4'hB, 16'd11);
        wr(4'hC, 16'd2);
        wr(4'hD, 16'd0);
        wr(4'hE, 16'd10);
        wr(4'hA, 16'd0);
        wr(4'h0, 16'h0002);
        expect_pulse(3, 9, 12, "R4");
        expect_pulse(4, 11, 12, "R4");
        expect_pulse(5, 1, 12, "R4");
        drain();

        // R7: duty equal to period keeps a polarity-0 pin high
        wr(4'h0, 16'h0000);
        wr(4'h1, 16'h0000);
        wr(4'h5, 16'd9);
        wr(4'h2, 16'd0);
        wr(4'h0, 16'h0001);
        idle(15);
        lows = 0;
        for (int i = 0; i < 30; i++) begin
            if (pwm[1] !== 1'b1) lows++;
            @(negedge clk);
        end
        check(lows == 0, "R7", "pin1 low cycles", lows, 0);

        // R8: channel 1 cleared by channel 0 wrap, own period 50 unused
        wr(4'h0, 16'h0000);
        wr(4'h2, 16'd0);
        wr(4'hA, 16'd0);
        wr(4'hB, 16'd50);
        wr(4'hC, 16'd4);
        wr(4'h0, 16'h000F);
        expect_pulse(3, 5, 10, "R8");
        expect_pulse(0, 4, 10, "R8");
        drain();

        // R9: sync preset loads both counters, waveforms then coincide
        wr(4'h0, 16'h0004);
        wr(4'h3, 16'd19);
        wr(4'hB, 16'd19);
        wr(4'h4, 16'd9);
        wr(4'hC, 16'd9);
        wr(4'hA, 16'd15);
        wr(4'h0, 16'h0007);
        mism = 0;
        rises = 0;
        prev = pwm[0];
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (pwm[0] !== pwm[3]) mism++;
            if (pwm[0] === 1'b1 && prev === 1'b0) rises++;
            prev = pwm[0];
        end
        check(mism == 0, "R9", "pin0/pin3 mismatched cycles", mism, 0);
        check(rises >= 2, "R9", "pin0 rising edges", rises, 2);

        // R10 R11: half-rate tick doubles every duration in clocks
        wr(4'h0, 16'h0000);
        wr(4'h2, 16'd0);
        wr(4'h3, 16'd9);
        wr(4'h4, 16'd3);
        tick_half = 1'b1;
        wr(4'h0, 16'h0001);
        expect_pulse(0, 8, 20, "R10");
        drain();
        tick_half = 1'b0;

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule